// File: doc/BRIEF.md
# SPI Flash Opcode Dispatcher

This block sits behind the byte deserialiser of an SPI device that emulates a serial flash. It looks at the first byte of each transaction and compares it with a command table that software loads at run time. It then commits to one downstream datapath: status read, identification read, discoverable-parameter read, ordinary read, command upload, 4-byte address entry or exit, or write enable or disable. After that it holds the choice until the transaction ends. The same decode serves the device's own flash mode and its passthrough mode. In passthrough, three commands (status, identification, parameter read) are taken over only when their intercept enable is set, and a sticky intercept flag records each takeover.

Each table entry carries a valid bit, an upload bit and an opcode. When several entries match, the lowest slot wins. Chip-select deassertion drives the synchronous reset, so every transaction starts from idle.

Top module: `spi_op_dispatch`

## Requirements
- R1: An entry matches only when its valid bit is set and its opcode equals the received byte. A byte that matches no valid entry is treated as unknown.
- R2: When more than one valid entry matches, the entry with the lowest slot index decides the datapath and is the one latched.
- R3: The slot layout is fixed. Slots 0 to 2 are status reads, slot 3 is identification, slot 4 is parameter read, slot 5 is enter-4B, slot 6 is exit-4B, slot 7 is write enable and slot 8 is write disable. Slots 9 and above select upload when the entry's upload bit is 1, and ordinary read when it is 0. Slot k occupies `table_i[k*10 +: 10]`, with the opcode in bits 7:0, the upload bit in bit 8 and the valid bit in bit 9.
- R4: The parser acts only in flash mode (`mode_i` = 2'b01) or passthrough mode (`mode_i` = 2'b10). With 2'b00 or 2'b11 it ignores bytes, stays idle and keeps all outputs zero.
- R5: Decoding takes place only in idle, on a byte with `byte_vld_i` high. The datapath select, the latched entry and the flags appear after the clock edge that samples the byte. When nothing matches, the latched entry is zero.
- R6: `dp_sel_o` is encoded as follows: bit 0 status, bit 1 identification, bit 2 parameter read, bit 3 read, bit 4 upload, bit 5 enter-4B, bit 6 exit-4B, bit 7 write enable, bit 8 write disable. An unmatched byte moves the parser to a wait state with all select bits zero.
- R7: In flash mode, a status, identification or parameter-read opcode always selects its own datapath.
- R8: In passthrough mode, each of those three commands selects its datapath only when its enable in `icpt_en_i` is set (bit 0 status, bit 1 identification, bit 2 parameter read). When the enable is set, the same bit of `icpt_o` is also raised. When it is clear, the parser waits with a zero select. The flags are never raised in flash mode.
- R9: Once the parser has left idle, it holds its state, select, entry and flags. Later bytes have no effect until reset.
- R10: A synchronous high `rst` returns the parser to idle and clears the select, the entry and the flags.
- R11: At most one select bit is high at any time, and the state register always holds a legal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also driven by chip-select deassertion |
| mode_i | input | 2 | Device mode: 01 flash, 10 passthrough, other values inactive |
| byte_i | input | OP_W | Received byte |
| byte_vld_i | input | 1 | Strobe marking `byte_i` as valid |
| table_i | input | NUM_SLOTS*(OP_W+2) | Command table, one entry per slot |
| icpt_en_i | input | 3 | Passthrough intercept enables for status, identification and parameter read |
| dp_sel_o | output | 9 | One-hot datapath select |
| entry_o | output | OP_W+2 | Latched matching table entry |
| icpt_o | output | 3 | Sticky intercept flags |

## Verification
The assertions assume that the command table and the intercept enables stay constant while a transaction is in progress. They also assume that every transaction begins with a reset pulse, as chip-select deassertion gives in the system. The stimulus follows both assumptions. It loads the table once and pulses reset before every transaction. It changes the mode and the enables only in the cycle in which reset is released. Within those rules, the stimulus covers all four mode codes and all eight enable combinations against a table that contains a disabled slot, a duplicate opcode and an unused byte.

// File: rtl/op_dispatch_pkg.sv
package op_dispatch_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_STATUS, ST_JEDEC, ST_SFDP, ST_READ,
    ST_UPLOAD, ST_ADDR4B, ST_WREN, ST_WAIT
  } parse_st_e;

  localparam int unsigned DP_W   = 9;
  localparam int unsigned ICPT_W = 3;

  localparam int unsigned DP_STATUS = 0;
  localparam int unsigned DP_JEDEC  = 1;
  localparam int unsigned DP_SFDP   = 2;
  localparam int unsigned DP_READ   = 3;
  localparam int unsigned DP_UPLOAD = 4;
  localparam int unsigned DP_EN4B   = 5;
  localparam int unsigned DP_EX4B   = 6;
  localparam int unsigned DP_WREN   = 7;
  localparam int unsigned DP_WRDI   = 8;

  localparam logic [1:0] MODE_FLASH = 2'b01;
  localparam logic [1:0] MODE_PASS  = 2'b10;

endpackage

// File: rtl/op_match.sv
module op_match #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned OP_W      = 8,
  localparam int unsigned ENT_W    = OP_W + 2,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS*ENT_W-1:0] table_i,
  input  logic [OP_W-1:0]            byte_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [ENT_W-1:0]           entry_o
);

  logic [NUM_SLOTS-1:0] eq;

  // one comparator per slot: valid bit and opcode equality
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign eq[s] = table_i[s*ENT_W + OP_W + 1] &&
                   (table_i[s*ENT_W +: OP_W] == byte_i);
  end

  // lowest index wins: scan downward so the last write is the lowest hit
  always_comb begin
    hit_o   = 1'b0;
    idx_o   = '0;
    entry_o = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (eq[s]) begin
        hit_o   = 1'b1;
        idx_o   = IDX_W'(s);
        entry_o = table_i[s*ENT_W +: ENT_W];
      end
    end
  end

endmodule

// File: rtl/op_classify.sv
module op_classify
  import op_dispatch_pkg::*;
#(
  parameter int unsigned NUM_STATUS = 3,
  parameter int unsigned IDX_W      = 4
) (
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              upload_i,
  input  logic [1:0]        mode_i,
  input  logic [ICPT_W-1:0] icpt_en_i,
  output parse_st_e         nxt_st_o,
  output logic [DP_W-1:0]   nxt_sel_o,
  output logic [ICPT_W-1:0] nxt_flag_o
);

  localparam int unsigned SLOT_JEDEC = NUM_STATUS;
  localparam int unsigned SLOT_SFDP  = NUM_STATUS + 1;
  localparam int unsigned SLOT_EN4B  = NUM_STATUS + 2;
  localparam int unsigned SLOT_EX4B  = NUM_STATUS + 3;
  localparam int unsigned SLOT_WREN  = NUM_STATUS + 4;
  localparam int unsigned SLOT_WRDI  = NUM_STATUS + 5;

  logic        in_flash;
  logic        in_pass;
  int unsigned idx;

  assign in_flash = (mode_i == MODE_FLASH);
  assign in_pass  = (mode_i == MODE_PASS);
  assign idx      = int'(idx_i);

  always_comb begin
    nxt_st_o   = ST_WAIT;
    nxt_sel_o  = '0;
    nxt_flag_o = '0;
    if (hit_i) begin
      if (idx < NUM_STATUS) begin
        if (in_flash || icpt_en_i[0]) begin
          nxt_st_o             = ST_STATUS;
          nxt_sel_o[DP_STATUS] = 1'b1;
          nxt_flag_o[0]        = in_pass;
        end
      end else if (idx == SLOT_JEDEC) begin
        if (in_flash || icpt_en_i[1]) begin
          nxt_st_o            = ST_JEDEC;
          nxt_sel_o[DP_JEDEC] = 1'b1;
          nxt_flag_o[1]       = in_pass;
        end
      end else if (idx == SLOT_SFDP) begin
        if (in_flash || icpt_en_i[2]) begin
          nxt_st_o           = ST_SFDP;
          nxt_sel_o[DP_SFDP] = 1'b1;
          nxt_flag_o[2]      = in_pass;
        end
      end else if (idx == SLOT_EN4B || idx == SLOT_EX4B) begin
        nxt_st_o = ST_ADDR4B;
        if (idx == SLOT_EN4B) nxt_sel_o[DP_EN4B] = 1'b1;
        else                  nxt_sel_o[DP_EX4B] = 1'b1;
      end else if (idx == SLOT_WREN || idx == SLOT_WRDI) begin
        nxt_st_o = ST_WREN;
        if (idx == SLOT_WREN) nxt_sel_o[DP_WREN] = 1'b1;
        else                  nxt_sel_o[DP_WRDI] = 1'b1;
      end else if (upload_i) begin
        nxt_st_o             = ST_UPLOAD;
        nxt_sel_o[DP_UPLOAD] = 1'b1;
      end else begin
        nxt_st_o           = ST_READ;
        nxt_sel_o[DP_READ] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_op_dispatch.sv
module spi_op_dispatch
  import op_dispatch_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 16,
  parameter int unsigned OP_W       = 8,
  parameter int unsigned NUM_STATUS = 3,
  localparam int unsigned ENT_W     = OP_W + 2,
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 mode_i,
  input  logic [OP_W-1:0]            byte_i,
  input  logic                       byte_vld_i,
  input  logic [NUM_SLOTS*ENT_W-1:0] table_i,
  input  logic [ICPT_W-1:0]          icpt_en_i,
  output logic [DP_W-1:0]            dp_sel_o,
  output logic [ENT_W-1:0]           entry_o,
  output logic [ICPT_W-1:0]          icpt_o
);

  parse_st_e         st_q;
  parse_st_e         nxt_st;
  logic [DP_W-1:0]   nxt_sel;
  logic [ICPT_W-1:0] nxt_flag;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [ENT_W-1:0]  hit_entry;
  logic              active;
  logic              take;

  assign active = (mode_i == MODE_FLASH) || (mode_i == MODE_PASS);
  assign take   = (st_q == ST_IDLE) && active && byte_vld_i;

  op_match #(.NUM_SLOTS(NUM_SLOTS), .OP_W(OP_W)) u_match (
    .table_i (table_i),
    .byte_i  (byte_i),
    .hit_o   (hit),
    .idx_o   (hit_idx),
    .entry_o (hit_entry)
  );

  op_classify #(.NUM_STATUS(NUM_STATUS), .IDX_W(IDX_W)) u_classify (
    .hit_i      (hit),
    .idx_i      (hit_idx),
    .upload_i   (hit_entry[OP_W]),
    .mode_i     (mode_i),
    .icpt_en_i  (icpt_en_i),
    .nxt_st_o   (nxt_st),
    .nxt_sel_o  (nxt_sel),
    .nxt_flag_o (nxt_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      dp_sel_o <= '0;
      entry_o  <= '0;
      icpt_o   <= '0;
    end else if (take) begin
      st_q     <= nxt_st;
      dp_sel_o <= nxt_sel;
      entry_o  <= hit_entry;
      icpt_o   <= nxt_flag;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dp_sel_o)); // R11
  AST_ST_LEGAL: assert property (@(posedge clk) disable iff (rst)
    st_q <= ST_WAIT); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |-> (dp_sel_o == '0 && icpt_o == '0)); // R5
  AST_WAIT_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> (dp_sel_o == '0)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> ($stable(st_q) && $stable(dp_sel_o) &&
                           $stable(entry_o) && $stable(icpt_o))); // R9
  AST_INACTIVE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && mode_i != MODE_FLASH && mode_i != MODE_PASS)
      |=> (st_q == ST_IDLE)); // R4
  AST_FLAG_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(|icpt_o) |-> $past(mode_i == MODE_PASS)); // R8

endmodule

// File: tb/spi_op_dispatch_tb.sv
module spi_op_dispatch_tb;

  localparam int NS = 16;
  localparam int EW = 10;

  typedef struct packed {
    logic [8:0] sel;
    logic [2:0] fl;
    logic [9:0] ent;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     mode = 2'b00;
  logic [7:0]     bval = 8'h00;
  logic           vld = 1'b0;
  logic [NS*EW-1:0] table_v;
  logic [2:0]     ie = 3'b000;
  logic [8:0]     dp_sel_o;
  logic [9:0]     entry_o;
  logic [2:0]     icpt_o;

  logic [9:0] tbl [NS];
  logic [7:0] blist [16];
  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;
  event  mon_ev;

  always #10 clk = ~clk;

  spi_op_dispatch u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .byte_i(bval), .byte_vld_i(vld),
    .table_i(table_v), .icpt_en_i(ie), .dp_sel_o(dp_sel_o),
    .entry_o(entry_o), .icpt_o(icpt_o)
  );

  // reference model written from R1, R2, R3, R6, R7, R8
  function automatic exp_t model(input logic [1:0] md, input logic [7:0] b,
                                 input logic [2:0] en, output int slot);
    exp_t r;
    r = '0;
    slot = -1;
    for (int s = NS - 1; s >= 0; s--)
      if (tbl[s][9] && tbl[s][7:0] == b) slot = s;
    if (md != 2'b01 && md != 2'b10) return r;
    if (slot < 0) return r;
    r.ent = tbl[slot];
    if (slot <= 4) begin
      int k;
      k = (slot <= 2) ? 0 : slot - 2;
      if (md == 2'b01 || en[k]) begin
        r.sel[k] = 1'b1;
        r.fl[k]  = (md == 2'b10);
      end
    end else if (slot <= 8) r.sel[slot] = 1'b1;
    else if (tbl[slot][8])  r.sel[4] = 1'b1;
    else                    r.sel[3] = 1'b1;
    return r;
  endfunction

  // monitor: pops expected items and compares
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({dp_sel_o, icpt_o, entry_o} !== e) begin
          fails++;
          $display("FAIL %s: sel=%b flags=%b entry=%h expected sel=%b flags=%b entry=%h",
                   t, dp_sel_o, icpt_o, entry_o, e.sel, e.fl, e.ent);
        end
        checks++;
        if ($countones(dp_sel_o) > 1) begin
          fails++;
          $display("FAIL R11: sel=%b expected at most one bit set", dp_sel_o);
        end
      end
    end
  end

  task automatic push(input exp_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> mon_ev;
  endtask

  task automatic run_txn(input logic [1:0] md, input logic [7:0] b, input logic [2:0] en);
    exp_t  e;
    int    slot;
    string t;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; mode = md; ie = en; bval = b; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    e = model(md, b, en, slot);
    if (md != 2'b01 && md != 2'b10) t = "R4";
    else if (b == 8'h05)               t = "R2";
    else if (b == 8'h35 || b == 8'h77) t = "R1";
    else if (slot < 0)                 t = "R6";
    else if (slot <= 4)                t = (md == 2'b10) ? "R8" : "R7";
    else if (slot <= 8)                t = "R3";
    else                               t = "R5";
    push(e, t);
    // a second byte must leave everything unchanged (R9)
    bval = (b == 8'h9F) ? 8'h03 : 8'h9F;
    vld  = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    push(e, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R3 layout: {valid, upload, opcode}
    tbl[0]  = {1'b1, 1'b0, 8'h05};
    tbl[1]  = {1'b0, 1'b0, 8'h35}; // disabled slot for R1
    tbl[2]  = {1'b1, 1'b0, 8'h15};
    tbl[3]  = {1'b1, 1'b0, 8'h9F};
    tbl[4]  = {1'b1, 1'b0, 8'h5A};
    tbl[5]  = {1'b1, 1'b0, 8'hB7};
    tbl[6]  = {1'b1, 1'b0, 8'hE9};
    tbl[7]  = {1'b1, 1'b0, 8'h06};
    tbl[8]  = {1'b1, 1'b0, 8'h04};
    tbl[9]  = {1'b1, 1'b0, 8'h03};
    tbl[10] = {1'b1, 1'b0, 8'h0B};
    tbl[11] = {1'b1, 1'b1, 8'h02};
    tbl[12] = {1'b1, 1'b1, 8'h20};
    tbl[13] = {1'b1, 1'b0, 8'h05}; // duplicate of slot 0 for R2
    tbl[14] = {1'b0, 1'b1, 8'h77}; // disabled slot for R1
    tbl[15] = {1'b1, 1'b0, 8'h3B};
    for (int s = 0; s < NS; s++) table_v[s*EW +: EW] = tbl[s];
    blist = '{8'h05, 8'h35, 8'h15, 8'h9F, 8'h5A, 8'hB7, 8'hE9, 8'h06,
              8'h04, 8'h03, 8'h0B, 8'h02, 8'h20, 8'h3B, 8'h77, 8'hAA};

    // R10: reset state
    repeat (2) @(negedge clk);
    push('0, "R10");

    for (int m = 0; m < 4; m++)
      for (int en = 0; en < 8; en++)
        for (int i = 0; i < 16; i++)
          run_txn(2'(m), blist[i], 3'(en));

    // R10: reset in the middle of a held transaction
    run_txn(2'b10, 8'h9F, 3'b010);
    rst = 1'b1;
    @(negedge clk);
    push('0, "R10");
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule